// File: doc/BRIEF.md
# Per-Row Symmetric Integer Quantizer

This block converts a stream of signed fixed-point weight elements into narrow signed integers. Each element carries a row index and a last-in-row flag, and every row (output channel) has its own scale. A mode input selects between two passes over the same stream interface.

In the calibrate pass the block keeps a running peak magnitude for each row. When the last element of a row is accepted it turns that peak into a reciprocal scale factor and stores it in a per-row register. Calibrate traffic produces no output. In the quantize pass each element is multiplied by its row's reciprocal and rounded. An optional zero point is then added, and the result is clamped to the signed range of the output width. Elements of a row that has never been calibrated are held off through the ready signal.

Division by the scale (peak / qmax) is replaced by multiplication with a stored reciprocal, so the quantize path needs no divider. The reciprocal has a fixed number of fraction bits, `RF`. The output width `NBITS` is a parameter from 4 to 8. `ROWS` must be a power of two and at least 2.

Top module: `pcq_quantizer`

## Requirements
- R1: After reset `out_valid_o` is 0 and no row has a scale: in quantize mode (`mode_i`=1) `in_ready_o` is 0 for every row index.
- R2: In calibrate mode (`mode_i`=0) `in_ready_o` is 1 and no output element is produced. Only accepted elements (valid and ready both high) update a row's running peak. Data presented while `in_valid_i` is 0 has no effect.
- R3: Accepting a calibrate element with `in_last_i`=1 stores the row's reciprocal as floor(qmax*2^RF / M). M is the row's peak magnitude including that element, with M=1 used when the peak is 0. The row's peak then restarts from 0, so a later pass replaces the scale.
- R4: In quantize mode the result is round-half-away-from-zero of x*recip/2^RF. Here x is the signed input, recip is the row's stored reciprocal and qmax = 2^(NBITS-1)-1.
- R5: With `asym_i`=0 the zero point is 0, and the value on `zp_i` has no effect on the output.
- R6: With `asym_i`=1 the two's-complement value of `zp_i` is added to the rounded result before clamping.
- R7: Any result below -(qmax+1) is output as -(qmax+1), and any result above qmax is output as qmax. This covers inputs larger than the calibrated peak and sums pushed out of range by the zero point.
- R8: In quantize mode an element whose row has no stored scale is not accepted (`in_ready_o`=0) and produces no output. Rows that do have a scale are accepted when the output register is free.
- R9: The output is registered. An element accepted at a clock edge appears on the next cycle with its row index and last flag. The output holds steady while `out_valid_o`=1 and `out_ready_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = calibrate, 1 = quantize |
| asym_i | input | 1 | 1 = add `zp_i` as zero point |
| zp_i | input | NBITS | Signed zero point |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Input element accepted when high with valid |
| in_data_i | input | DATA_W | Signed fixed-point element |
| in_row_i | input | $clog2(ROWS) | Row (output channel) of the element |
| in_last_i | input | 1 | Element is the last of its row |
| out_valid_o | output | 1 | Quantized element valid |
| out_ready_i | input | 1 | Downstream accepts the quantized element |
| out_q_o | output | NBITS | Signed quantized value |
| out_row_o | output | $clog2(ROWS) | Row of the quantized element |
| out_last_o | output | 1 | Last-in-row flag of the quantized element |

## Verification
The assertions check, on every cycle, the protocol properties that follow from state alone:
- an uncalibrated row is never accepted in quantize mode;
- a row's scale flag becomes set after its final calibrate element and never clears;
- calibrate traffic never creates output;
- a stalled output does not change.

The arithmetic cannot be shown by a property and is left to the bench's sweeps. These include the reciprocal, rounding ties, the floor for an all-zero row, the zero-point add and both clamp bounds. Every input value is swept against several calibrated peaks, in both zero-point modes, under irregular back-pressure. The bench also covers input ignored while valid is low, and the replacement of a scale by a later calibration.

// File: rtl/pcq_pkg.sv
`timescale 1ns/1ps
package pcq_pkg;

  typedef enum logic {PCQ_CAL = 1'b0, PCQ_QNT = 1'b1} pcq_mode_e;

  // magnitude of a signed value
  function automatic longint mag_of(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // larger of two values
  function automatic longint max_of(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  // reciprocal scale: qmax * 2^rf / peak, peak floored at 1
  function automatic longint recip_of(input longint peak, input longint qmax, input int rf);
    longint d;
    d = (peak == 0) ? 64'sd1 : peak;
    return (qmax <<< rf) / d;
  endfunction

  // x * r / 2^rf, rounded half away from zero
  function automatic longint round_scaled(input longint x, input longint r, input int rf);
    longint p;
    longint h;
    p = x * r;
    h = 64'sd1 <<< (rf - 1);
    if (p >= 0) return (p + h) >>> rf;
    return -((h - p) >>> rf);
  endfunction

  // saturate into [lo, hi]
  function automatic longint clamp_q(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pcq_scale_bank.sv
`timescale 1ns/1ps
module pcq_scale_bank #(
  parameter int DATA_W = 12,
  parameter int ROWS   = 8,
  parameter int NBITS  = 8,
  parameter int RF     = 16,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int RECIP_W = NBITS - 1 + RF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_i,
  input  logic [ROW_W-1:0]         row_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic                     last_i,
  output logic [RECIP_W-1:0]       recip_o,
  output logic [ROWS-1:0]          row_ok_o,
  output logic                     latch_o
);
  import pcq_pkg::*;

  localparam longint QMAX = (64'sd1 <<< (NBITS - 1)) - 1;

  logic [DATA_W-1:0]  peak_v  [ROWS];
  logic [RECIP_W-1:0] recip_v [ROWS];
  logic [DATA_W-1:0]  next_peak;
  logic [RECIP_W-1:0] next_recip;

  always_comb begin
    next_peak  = DATA_W'(max_of(mag_of(longint'(data_i)), longint'(peak_v[row_i])));
    next_recip = RECIP_W'(recip_of(longint'(next_peak), QMAX, RF));
  end

  assign latch_o = upd_i & last_i;
  assign recip_o = recip_v[row_i];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [DATA_W-1:0]  peak_q;
    logic [RECIP_W-1:0] recip_q;
    logic               ok_q;
    logic               hit;

    assign hit = upd_i && (row_i == ROW_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        peak_q  <= '0;
        recip_q <= '0;
        ok_q    <= 1'b0;
      end else if (hit) begin
        if (last_i) begin
          peak_q  <= '0;
          recip_q <= next_recip;
          ok_q    <= 1'b1;
        end else begin
          peak_q  <= next_peak;
        end
      end
    end

    assign peak_v[g]   = peak_q;
    assign recip_v[g]  = recip_q;
    assign row_ok_o[g] = ok_q;
  end

endmodule

// File: rtl/pcq_quant_stage.sv
`timescale 1ns/1ps
module pcq_quant_stage #(
  parameter int DATA_W = 12,
  parameter int ROWS   = 8,
  parameter int NBITS  = 8,
  parameter int RF     = 16,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int RECIP_W = NBITS - 1 + RF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic [RECIP_W-1:0]       recip_i,
  input  logic [ROW_W-1:0]         row_i,
  input  logic                     last_i,
  input  logic                     asym_i,
  input  logic signed [NBITS-1:0]  zp_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic [NBITS-1:0]         q_o,
  output logic [ROW_W-1:0]         row_o,
  output logic                     last_o
);
  import pcq_pkg::*;

  localparam longint QMAX = (64'sd1 <<< (NBITS - 1)) - 1;
  localparam longint QMIN = -QMAX - 1;

  logic [NBITS-1:0] q_next;

  always_comb begin
    q_next = NBITS'(clamp_q(
               round_scaled(longint'(x_i), longint'(recip_i), RF)
               + (asym_i ? longint'(zp_i) : 64'sd0),
               QMIN, QMAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
      row_o       <= '0;
      last_o      <= 1'b0;
    end else if (take_i) begin
      out_valid_o <= 1'b1;
      q_o         <= q_next;
      row_o       <= row_i;
      last_o      <= last_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pcq_quantizer.sv
`timescale 1ns/1ps
module pcq_quantizer #(
  parameter int DATA_W = 12,
  parameter int ROWS   = 8,
  parameter int NBITS  = 8,
  parameter int RF     = 16,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int RECIP_W = NBITS - 1 + RF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_i,
  input  logic                     asym_i,
  input  logic signed [NBITS-1:0]  zp_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic [ROW_W-1:0]         in_row_i,
  input  logic                     in_last_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [NBITS-1:0]         out_q_o,
  output logic [ROW_W-1:0]         out_row_o,
  output logic                     out_last_o
);
  import pcq_pkg::*;

  pcq_mode_e          mode_w;
  logic [ROWS-1:0]    row_ok_w;
  logic [RECIP_W-1:0] recip_w;
  logic               latch_evt_w;
  logic               stall_w;
  logic               cal_fire_w;
  logic               qnt_fire_w;

  assign mode_w     = pcq_mode_e'(mode_i);
  assign stall_w    = out_valid_o & ~out_ready_i;
  assign in_ready_o = (mode_w == PCQ_QNT) ? (row_ok_w[in_row_i] & ~stall_w) : 1'b1;
  assign cal_fire_w = in_valid_i & in_ready_o & (mode_w == PCQ_CAL);
  assign qnt_fire_w = in_valid_i & in_ready_o & (mode_w == PCQ_QNT);

  pcq_scale_bank #(
    .DATA_W(DATA_W), .ROWS(ROWS), .NBITS(NBITS), .RF(RF)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (cal_fire_w),
    .row_i    (in_row_i),
    .data_i   (in_data_i),
    .last_i   (in_last_i),
    .recip_o  (recip_w),
    .row_ok_o (row_ok_w),
    .latch_o  (latch_evt_w)
  );

  pcq_quant_stage #(
    .DATA_W(DATA_W), .ROWS(ROWS), .NBITS(NBITS), .RF(RF)
  ) u_quant (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (qnt_fire_w),
    .x_i         (in_data_i),
    .recip_i     (recip_w),
    .row_i       (in_row_i),
    .last_i      (in_last_i),
    .asym_i      (asym_i),
    .zp_i        (zp_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .q_o         (out_q_o),
    .row_o       (out_row_o),
    .last_o      (out_last_o)
  );

endmodule

// File: rtl/pcq_quantizer_chk.sv
`timescale 1ns/1ps
module pcq_quantizer_chk #(
  parameter int ROWS  = 8,
  parameter int NBITS = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [ROW_W-1:0] in_row_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [NBITS-1:0] out_q_o,
  input logic [ROWS-1:0]  row_ok_w,
  input logic             latch_evt_w
);

  // R8
  no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && in_valid_i && !row_ok_w[in_row_i]) |-> !in_ready_o);

  // R3
  latch_sets_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt_w |=> row_ok_w[$past(in_row_i)]);

  // R3
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_ok_w & $past(row_ok_w)) == $past(row_ok_w)));

  // R2
  cal_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !out_valid_o) |=> !out_valid_o);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_q_o)));

endmodule

bind pcq_quantizer pcq_quantizer_chk #(.ROWS(ROWS), .NBITS(NBITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_row_i    (in_row_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_q_o     (out_q_o),
  .row_ok_w    (row_ok_w),
  .latch_evt_w (latch_evt_w)
);

// File: tb/sim_pcq_quantizer.sv
`timescale 1ns/1ps
module sim_pcq_quantizer;
  localparam int DW = 8;
  localparam int NR = 4;
  localparam int NB = 8;
  localparam int FB = 16;
  localparam int QM = (1 << (NB - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic asym = 1'b0;
  logic signed [NB-1:0] zp = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic [1:0] in_row = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NB-1:0] out_q;
  logic [1:0] out_row;
  logic out_last;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;
  int peak [NR];
  string tag = "R4";

  int    eq_q[$];
  int    eq_row[$];
  bit    eq_last[$];
  string eq_tag[$];

  pcq_quantizer #(.DATA_W(DW), .ROWS(NR), .NBITS(NB), .RF(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .asym_i(asym), .zp_i(zp),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_row_i(in_row), .in_last_i(in_last), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_q_o(out_q), .out_row_o(out_row),
    .out_last_o(out_last)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model: scale = peak/qmax via a floored reciprocal, rounding ties away from zero
  function automatic int model_q(input int x, input int pk, input bit use_zp, input int z);
    longint d, r, a, k, v;
    d = (pk == 0) ? 1 : pk;
    r = (longint'(QM) * 65536) / d;
    a = longint'((x < 0) ? -x : x) * r;
    k = (a + 32768) / 65536;
    v = (x < 0) ? -k : k;
    if (use_zp) v = v + z;
    if (v > QM) v = QM;
    if (v < -QM - 1) v = -QM - 1;
    return int'(v);
  endfunction

  task automatic send(input int x, input int row, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    in_row   = 2'(row);
    in_last  = last;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    if (mode) begin
      eq_q.push_back(model_q(x, peak[row], asym, int'(zp)));
      eq_row.push_back(row);
      eq_last.push_back(last);
      eq_tag.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input int row);
    for (int x = -(1 << (DW - 1)); x < (1 << (DW - 1)); x++)
      send(x, row, x == (1 << (DW - 1)) - 1);
    idle();
  endtask

  // back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = bp_en ? ((cyc % 5 != 3) && (cyc % 7 != 0)) : 1'b1;
    end
  end

  // output monitor
  initial begin
    bit prev_stall = 1'b0;
    int prev_q = 0;
    int e, er;
    bit el;
    string et;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (prev_stall) begin
          // R9 output held under stall
          chk(out_valid && (int'($signed(out_q)) == prev_q), "R9", "held output",
              int'($signed(out_q)), prev_q);
        end
        if (out_valid && out_ready) begin
          if (eq_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected output", int'($signed(out_q)), 0);
          end else begin
            e  = eq_q.pop_front();
            er = eq_row.pop_front();
            el = eq_last.pop_front();
            et = eq_tag.pop_front();
            chk(int'($signed(out_q)) == e, et, "quantized value", int'($signed(out_q)), e);
            chk({out_row, out_last} == {2'(er), el}, "R9", "row/last tag",
                int'({out_row, out_last}), int'({2'(er), el}));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_q     = int'($signed(out_q));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    #5;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    mode = 1'b1;
    for (int r = 0; r < NR; r++) begin
      in_row = 2'(r);
      #1;
      chk(in_ready == 1'b0, "R1", "ready with no scale", int'(in_ready), 0);
    end
    mode = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R2", "ready in calibrate", int'(in_ready), 1);

    // R8 uncalibrated row held off, nothing produced
    @(negedge clk);
    mode = 1'b1;
    in_valid = 1'b1;
    in_row = 2'd2;
    in_data = 8'sd50;
    for (int k = 0; k < 3; k++) begin
      #5;
      chk(in_ready == 1'b0, "R8", "ready on uncalibrated row", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R8", "no output from refused input", int'(out_valid), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    mode = 1'b0;

    // calibrate row 0: peak 100
    for (int v = -100; v < 100; v += 7) send(v, 0, 1'b0);
    send(100, 0, 1'b1);
    idle();
    peak[0] = 100;

    // R8 row with scale accepted, row without refused
    @(negedge clk);
    mode = 1'b1;
    in_row = 2'd0;
    #5;
    chk(in_ready == 1'b1, "R8", "ready on calibrated row", int'(in_ready), 1);
    in_row = 2'd1;
    #1;
    chk(in_ready == 1'b0, "R8", "ready on other row", int'(in_ready), 0);
    @(negedge clk);
    mode = 1'b0;

    // row 1: all zero, scale floor
    for (int k = 0; k < 3; k++) send(0, 1, 1'b0);
    send(0, 1, 1'b1);
    // row 2: peak 128 from the most negative input
    send(10, 2, 1'b0);
    send(-128, 2, 1'b0);
    send(5, 2, 1'b1);
    idle();
    peak[1] = 0;
    peak[2] = 128;

    // row 3: R2 data with valid low is ignored
    @(negedge clk);
    in_valid = 1'b0;
    in_row = 2'd3;
    in_data = 8'sd127;
    in_last = 1'b0;
    @(negedge clk);
    @(negedge clk);
    send(3, 3, 1'b0);
    send(-5, 3, 1'b0);
    send(2, 3, 1'b1);
    idle();
    peak[3] = 5;
    #5;
    chk(out_valid == 1'b0, "R2", "no output after calibrate", int'(out_valid), 0);

    // symmetric sweeps, zp held nonzero to show it is ignored
    @(negedge clk);
    mode = 1'b1;
    asym = 1'b0;
    zp = 8'sd55;
    bp_en = 1'b1;
    tag = "R4"; sweep(0);
    tag = "R3"; sweep(1);
    tag = "R5"; sweep(2);
    tag = "R2"; sweep(3);

    // asymmetric sweeps, both clamp ends
    asym = 1'b1;
    zp = 8'sd20;
    tag = "R6"; sweep(0);
    zp = -8'sd30;
    tag = "R7"; sweep(2);

    // R3 recalibration replaces the scale
    @(negedge clk);
    mode = 1'b0;
    asym = 1'b0;
    send(-40, 0, 1'b0);
    send(12, 0, 1'b0);
    send(40, 0, 1'b1);
    idle();
    peak[0] = 40;
    @(negedge clk);
    mode = 1'b1;
    tag = "R3"; sweep(0);

    // drain
    bp_en = 1'b0;
    for (int k = 0; k < 50 && eq_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(eq_q.size() == 0, "R9", "all accepted elements emitted", eq_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule